// File: doc/BRIEF.md
# Interval Timer with Coherent Count Capture

This block is a 32-bit down-counting interval timer on a small word-addressed register bus. Software loads a 32-bit reload value in two 16-bit pieces, picks single-shot or free-running (continuous) operation, and issues start and stop commands through a control register. Each time the count expires, a sticky timeout flag is raised. An interrupt line reports that flag when software has enabled it.

The live count keeps moving while software reads it, so it is never read directly. Any write to the capture register copies the whole 32-bit count into a holding register in one cycle. Software then reads the two 16-bit halves of that copy at leisure, and the halves always belong to the same instant. The count runs downward, so software inverts the captured value when it wants an up-count.

Top module: `snap_timer`

## Requirements
- R1: After reset, status and control read 0, both period halves read 0xFFFF, the counter holds 0xFFFFFFFF, the timer is stopped and the interrupt output is 0.
- R2: Registers sit at word indices 0 status, 1 control, 2 period bits 15:0, 3 period bits 31:16, 4 capture bits 15:0, 5 capture bits 31:16. Read data bits above 15 are always 0, write data bits above 15 are ignored, indices 6 and 7 read 0 and ignore writes, and index 5 ignores writes.
- R3: A write to index 2 or 3 replaces that half of the period, loads the whole new period into the counter and stops the timer.
- R4: Control bit 0 is the interrupt enable and bit 1 selects continuous mode; both read back. Bit 2 starts and bit 3 stops the timer; both act only in the write cycle and read back as 0. When both are 1 in one write, the timer ends up stopped.
- R5: While running, the counter decreases by one per cycle. In a running cycle where it is 0, it reloads the period and a timeout occurs, so one interval lasts period+1 cycles.
- R6: After a timeout in single-shot mode (control bit 1 = 0) the timer stops; in continuous mode it keeps running.
- R7: Status bit 0 is the timeout flag and bit 1 reads 1 while the timer runs. Any write to index 0 clears the flag, but a timeout in the same cycle leaves it set.
- R8: Any write to index 4, whatever its data, copies the counter value present in that cycle into the capture register. The copy does not change until the next capture, however long the counter keeps running.
- R9: The interrupt output is a register that equals timeout flag AND interrupt enable.
- R10: Read data shows the addressed register one cycle after the read strobe, with the value it had in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (3) | Word index |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The sharpest collision is a status-clear write that lands in the same cycle as a counter expiry. The bench sets a period of 1 in continuous mode and places the clear write exactly two cycles after the start write, which is the expiry cycle. It then requires status to read timeout set and running. A second collision is a capture write while the counter moves in that same cycle: two cycles after starting from 100, the capture must hold 99, the value before that edge's decrement, and must keep holding it on later reads.

// File: rtl/snap_timer_pkg.sv
package snap_timer_pkg;
  localparam int NUM_REGS    = 6;
  localparam int IDX_STAT    = 0;
  localparam int IDX_CTL     = 1;
  localparam int IDX_PER_LO  = 2;
  localparam int IDX_PER_HI  = 3;
  localparam int IDX_SNAP_LO = 4;
  localparam int IDX_SNAP_HI = 5;

  localparam int CTL_IEN   = 0;
  localparam int CTL_CONT  = 1;
  localparam int CTL_START = 2;
  localparam int CTL_STOP  = 3;

  localparam int STS_TO  = 0;
  localparam int STS_RUN = 1;

  typedef struct packed {
    logic cont;
    logic ien;
  } ctl_t;
endpackage

// File: rtl/snap_timer_decode.sv
module snap_timer_decode #(
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 6
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_REGS-1:0] we
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
    assign we[i] = wr && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/snap_timer_counter.sv
module snap_timer_counter #(
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              per_lo_we,
  input  logic              per_hi_we,
  input  logic [HALF_W-1:0] wdata,
  input  logic              start,
  input  logic              stop,
  input  logic              cont,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  per_o,
  output logic              run_o,
  output logic              wrap_o
);
  logic [CNT_W-1:0] per_q, per_nxt, cnt_q;
  logic             run_q, per_wr;

  assign per_wr = per_lo_we || per_hi_we;

  always_comb begin
    per_nxt = per_q;
    if (per_lo_we) per_nxt[HALF_W-1:0]     = wdata;
    if (per_hi_we) per_nxt[CNT_W-1:HALF_W] = wdata;
  end

  assign wrap_o = run_q && (cnt_q == '0) && !per_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '1;
      cnt_q <= '1;
      run_q <= 1'b0;
    end else begin
      per_q <= per_nxt;
      if (per_wr) begin
        cnt_q <= per_nxt;
        run_q <= 1'b0;
      end else begin
        if (run_q) cnt_q <= wrap_o ? per_q : cnt_q - 1'b1;
        if (stop)                run_q <= 1'b0;
        else if (start)          run_q <= 1'b1;
        else if (wrap_o && !cont) run_q <= 1'b0;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
  assign run_o = run_q;
endmodule

// File: rtl/snap_timer_latch.sv
module snap_timer_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)      hold_q <= '0;
    else if (cap) hold_q <= din;
  end

  assign dout = hold_q;
endmodule

// File: rtl/snap_timer.sv
module snap_timer
  import snap_timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] we;
  logic [CNT_W-1:0]    cnt_w, per_w, snap_w;
  logic                run_w, wrap_w;
  ctl_t                ctl_q, ctl_nxt;
  logic                to_q, to_nxt, irq_q;
  logic [HALF_W-1:0]   rd_half;
  logic [DATA_W-1:0]   rdata_q;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:HALF_W];

  snap_timer_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .we(we)
  );

  snap_timer_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst(rst),
    .per_lo_we(we[IDX_PER_LO]), .per_hi_we(we[IDX_PER_HI]),
    .wdata(bus_wdata[HALF_W-1:0]),
    .start(we[IDX_CTL] && bus_wdata[CTL_START]),
    .stop(we[IDX_CTL] && bus_wdata[CTL_STOP]),
    .cont(ctl_q.cont),
    .cnt_o(cnt_w), .per_o(per_w), .run_o(run_w), .wrap_o(wrap_w)
  );

  snap_timer_latch #(.W(CNT_W)) u_snap (
    .clk(clk), .rst(rst), .cap(we[IDX_SNAP_LO]), .din(cnt_w), .dout(snap_w)
  );

  always_comb begin
    ctl_nxt = ctl_q;
    if (we[IDX_CTL]) begin
      ctl_nxt.ien  = bus_wdata[CTL_IEN];
      ctl_nxt.cont = bus_wdata[CTL_CONT];
    end
    to_nxt = to_q;
    if (wrap_w)             to_nxt = 1'b1;
    else if (we[IDX_STAT])  to_nxt = 1'b0;
  end

  always_comb begin
    rd_half = '0;
    case (bus_addr)
      ADDR_W'(IDX_STAT): begin
        rd_half[STS_TO]  = to_q;
        rd_half[STS_RUN] = run_w;
      end
      ADDR_W'(IDX_CTL): begin
        rd_half[CTL_IEN]  = ctl_q.ien;
        rd_half[CTL_CONT] = ctl_q.cont;
      end
      ADDR_W'(IDX_PER_LO):  rd_half = per_w[HALF_W-1:0];
      ADDR_W'(IDX_PER_HI):  rd_half = per_w[CNT_W-1:HALF_W];
      ADDR_W'(IDX_SNAP_LO): rd_half = snap_w[HALF_W-1:0];
      ADDR_W'(IDX_SNAP_HI): rd_half = snap_w[CNT_W-1:HALF_W];
      default:              rd_half = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      to_q    <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctl_q <= ctl_nxt;
      to_q  <= to_nxt;
      irq_q <= to_nxt && ctl_nxt.ien;
      if (bus_rd) rdata_q <= DATA_W'(rd_half);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/snap_timer_checker.sv
module snap_timer_checker
  import snap_timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  snap,
  input logic              run,
  input logic              wrap,
  input logic              to_q,
  input ctl_t              ctl,
  input logic              irq
);
  logic per_write, ctl_write, stat_write, cap_write;
  assign per_write  = bus_wr && (bus_addr == ADDR_W'(IDX_PER_LO) || bus_addr == ADDR_W'(IDX_PER_HI));
  assign ctl_write  = bus_wr && (bus_addr == ADDR_W'(IDX_CTL));
  assign stat_write = bus_wr && (bus_addr == ADDR_W'(IDX_STAT));
  assign cap_write  = bus_wr && (bus_addr == ADDR_W'(IDX_SNAP_LO));

  AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (rst) (rdata >> HALF_W) == '0); // R2
  AST_PER_WR_STOPS: assert property (@(posedge clk) disable iff (rst) per_write |=> !run); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst) (ctl_write && bus_wdata[CTL_STOP]) |=> !run); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst) (run && cnt != '0 && !per_write) |=> cnt == $past(cnt) - 1'b1); // R5
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst) (wrap && !ctl.cont && !ctl_write) |=> !run); // R6
  AST_WRAP_SETS_TO: assert property (@(posedge clk) disable iff (rst) wrap |=> to_q); // R7
  AST_TO_STICKY: assert property (@(posedge clk) disable iff (rst) (to_q && !stat_write) |=> to_q); // R7
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst) cap_write |=> snap == $past(cnt)); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst) !cap_write |=> $stable(snap)); // R8
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst) irq == (to_q && ctl.ien)); // R9
endmodule

bind snap_timer snap_timer_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .rdata(bus_rdata), .cnt(cnt_w), .snap(snap_w), .run(run_w), .wrap(wrap_w),
  .to_q(to_q), .ctl(ctl_q), .irq(irq_o)
);

// File: tb/snap_timer_bench.sv
module snap_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          n_tests = 0;
  int          n_fail = 0;
  logic [31:0] got;

  always #2 clk = ~clk;

  snap_timer u_snap_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // {is_write, index, write data, expected read data, requirement number}
  localparam int NV = 23;
  localparam logic [71:0] VEC [0:NV-1] = '{
    {1'b0, 3'd0, 32'h0,        32'h0,    4'd1},  // R1 status
    {1'b0, 3'd1, 32'h0,        32'h0,    4'd1},  // R1 control
    {1'b0, 3'd2, 32'h0,        32'hFFFF, 4'd1},  // R1 period low
    {1'b0, 3'd3, 32'h0,        32'hFFFF, 4'd1},  // R1 period high
    {1'b1, 3'd4, 32'hDEAD,     32'h0,    4'd8},  // R8 capture
    {1'b0, 3'd4, 32'h0,        32'hFFFF, 4'd1},  // R1 counter all ones
    {1'b0, 3'd5, 32'h0,        32'hFFFF, 4'd1},
    {1'b1, 3'd2, 32'hABCD1234, 32'h0,    4'd2},  // R2 upper data ignored
    {1'b1, 3'd3, 32'h0001,     32'h0,    4'd3},
    {1'b0, 3'd2, 32'h0,        32'h1234, 4'd2},
    {1'b0, 3'd3, 32'h0,        32'h0001, 4'd3},
    {1'b1, 3'd4, 32'h0,        32'h0,    4'd8},
    {1'b0, 3'd4, 32'h0,        32'h1234, 4'd3},  // R3 period loaded
    {1'b0, 3'd5, 32'h0,        32'h0001, 4'd3},
    {1'b1, 3'd1, 32'h000F,     32'h0,    4'd4},  // R4 start+stop
    {1'b0, 3'd1, 32'h0,        32'h0003, 4'd4},
    {1'b0, 3'd0, 32'h0,        32'h0000, 4'd4},  // R4 stop wins
    {1'b0, 3'd6, 32'h0,        32'h0,    4'd2},
    {1'b1, 3'd6, 32'h5555,     32'h0,    4'd2},
    {1'b0, 3'd7, 32'h0,        32'h0,    4'd2},
    {1'b1, 3'd5, 32'h7777,     32'h0,    4'd2},
    {1'b0, 3'd5, 32'h0,        32'h0001, 4'd2},  // R2 index 5 read only
    {1'b0, 3'd1, 32'h0,        32'h0003, 4'd2}   // R2 index 6 write no effect
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71]) wr(VEC[i][70:68], VEC[i][67:36]);
      else begin
        rd(VEC[i][70:68], got);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), got, VEC[i][35:4]);
      end
    end
    wr(3'd1, 32'h0);

    // R5 R6: single-shot period 5, expiry on the 6th edge after start
    wr(3'd2, 32'd5); wr(3'd3, 32'd0);
    wr(3'd1, 32'h4);
    rd(3'd0, got); check("R5 run e2", got, 32'h2);
    rd(3'd0, got); check("R5 run e4", got, 32'h2);
    rd(3'd0, got); check("R5 no timeout e6", got, 32'h2);
    rd(3'd0, got); check("R6 oneshot halted", got, 32'h1);
    wr(3'd4, 32'h0);
    rd(3'd4, got); check("R5 reloaded", got, 32'd5);
    check("R9 irq disabled", {31'b0, irq_o}, 32'h0);
    wr(3'd1, 32'h1);
    check("R9 irq enabled", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'h0);
    check("R9 irq cleared", {31'b0, irq_o}, 32'h0);
    rd(3'd0, got); check("R7 cleared", got, 32'h0);

    // R8: capture two cycles after starting from 100, continuous
    wr(3'd2, 32'd100);
    wr(3'd1, 32'h6);
    wr(3'd4, 32'hFFFF);
    rd(3'd4, got); check("R8 capture lo", got, 32'd99);
    rd(3'd5, got); check("R8 capture hi", got, 32'd0);
    rd(3'd4, got); check("R8 capture holds", got, 32'd99);
    rd(3'd0, got); check("R10 running status", got, 32'h2);
    wr(3'd2, 32'd50);
    rd(3'd0, got); check("R3 period write stops", got, 32'h0);
    wr(3'd4, 32'h0);
    rd(3'd4, got); check("R3 count loaded", got, 32'd50);

    // R7: status clear in the expiry cycle, period 1 continuous
    wr(3'd2, 32'd1);
    wr(3'd1, 32'h6);
    wr(3'd0, 32'h0);
    rd(3'd0, got); check("R7 set wins over clear", got, 32'h3);
    wr(3'd1, 32'h8);
    wr(3'd0, 32'h0);
    rd(3'd0, got); check("R7 clear after stop", got, 32'h0);
    rd(3'd1, got); check("R4 strobes read zero", got, 32'h0);

    finish_run();
  end
endmodule